// File: doc/BRIEF.md
# Context-Dependent Effective Address Generator

This block forms the final address for a small set of special instructions: a general memory reference, a push-status reference, a modify-and-test reference, a direct read/write I/O reference, and the fetch of the interrupt stack pointer. The caller provides the instruction class, the execution context (normal program flow, a trap sequence or an interrupt sequence), the reference-address field, the index and indirect request bits, the index register value, the status-word mapping bit and an interrupt-counter-4 flag. The block returns the address together with two qualifiers: one says the address must go through the translation map, the other says it is a real memory address.

Indexing and mapping are decided by the class and the context together, not only by the instruction bits. When a push-status or modify-and-test instruction runs from a trap or interrupt location during that sequence, the reference field takes the place of the index designator, so indexing is suppressed. Direct I/O addresses are cut down to 16 bits and never mapped. When indirection is requested, the block issues a fetch address with its own map qualifier, holds that request until the indirect word arrives, and then finishes the calculation on that word.

Top module: `eag_core`

## Requirements
- R1: After reset, done_o, ind_req_o, use_map_o and real_o are 0 and addr_o is zero.
- R2: A start with no indirection (ind_en_i low, or class stack pointer) produces a one-cycle done_o pulse on the clock edge that samples start_i; ind_req_o stays low.
- R3: In normal context (ctx_i 0 or 3), and for the general class (cls_i 0) in any context, the address is the base plus the index value (when idx_en_i is set) as a 20-bit sum that wraps; use_map_o equals map_bit_i and real_o is its inverse.
- R4: For push-status (cls_i 1) or modify-and-test (cls_i 2) in trap (ctx_i 1) or interrupt (ctx_i 2) context, the index value is never added, whatever idx_en_i holds.
- R5: Push-status or modify-and-test in interrupt context gives a real, unmapped address even when map_bit_i is 1, except as in R6.
- R6: Modify-and-test in interrupt context with cnt4_i set is mapped exactly when map_bit_i is 1.
- R7: Modify-and-test in trap context follows map_bit_i; when it is mapped, address bits 14..12 are forced to zero, and when unmapped the address is passed unchanged as real.
- R8: Direct I/O (cls_i 3) adds the index when requested, keeps only the low 16 bits of the sum with bits 19..16 zero, and reports use_map_o 0 and real_o 0.
- R9: For direct I/O with indirection, the indirect fetch carries ind_map_o equal to map_bit_i, and the index is added to the returned word before truncation.
- R10: With indirection, ind_req_o rises on the edge that samples start_i with ind_addr_o equal to the reference field, stays high with a stable address until ind_valid_i is sampled, then drops as done_o pulses with the address built from ind_word_i; in trap/interrupt format the indirect word is not indexed and ind_map_o matches the final map decision.
- R11: The stack-pointer class (cls_i 4) yields address 0, real, unmapped, ignoring index and indirect bits.
- R12: A start_i while an indirect fetch is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an address calculation |
| cls_i | input | 3 | Instruction class: 0 general, 1 push-status, 2 modify-and-test, 3 direct I/O, 4 stack pointer |
| ctx_i | input | 2 | Context: 0 normal, 1 trap sequence, 2 interrupt sequence, 3 treated as normal |
| ref_i | input | 20 | Reference-address field |
| idx_en_i | input | 1 | Indexing requested by the instruction |
| ind_en_i | input | 1 | Indirection requested by the instruction |
| xval_i | input | 20 | Index register value |
| map_bit_i | input | 1 | Status-word mapping bit |
| cnt4_i | input | 1 | Instruction sits in interrupt counter 4 |
| ind_req_o | output | 1 | Indirect word fetch request |
| ind_addr_o | output | 20 | Indirect fetch address |
| ind_map_o | output | 1 | Indirect fetch goes through the map |
| ind_valid_i | input | 1 | Indirect word is valid |
| ind_word_i | input | 20 | Indirect word address field |
| done_o | output | 1 | Final address valid pulse |
| addr_o | output | 20 | Final address |
| use_map_o | output | 1 | Final address must be mapped |
| real_o | output | 1 | Final address is a real memory address |

## Verification
The bench targets the context rules where a design that only looked at the instruction bits would go wrong: a trap push-status with indexing requested (a faulty design adds the index), an interrupt modify-and-test with mapping on (it would map unless counter 4 is flagged), and a trapped, mapped modify-and-test whose reference has bits 14..12 set (a design missing the clear leaves 0x7000 in the address). Direct I/O is driven with a sum that carries past bit 16, so a design truncating before adding, or keeping 17 bits, produces a different value. The indirect path is held for several cycles with a stray start in between, which exposes a design that drops the request early, restarts, or indexes a trap-format indirect word.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [2:0] {
        CLS_GEN  = 3'd0,
        CLS_PUSH = 3'd1,
        CLS_MODT = 3'd2,
        CLS_DIO  = 3'd3,
        CLS_STK  = 3'd4
    } cls_e;

    typedef enum logic [1:0] {
        CTX_NORM = 2'd0,
        CTX_TRAP = 2'd1,
        CTX_INTR = 2'd2,
        CTX_RSVD = 2'd3
    } ctx_e;

    // Per-request address policy
    typedef struct packed {
        logic idx_ok;   // index value may be added
        logic map;      // final address goes through the map
        logic real_a;   // final address is a real memory address
        logic clr_fld;  // force the ignored field to zero
        logic trunc;    // keep only the device-address width
        logic zero;     // fixed address zero
    } policy_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

endpackage

// File: rtl/eag_policy.sv
module eag_policy
    import eag_pkg::*;
(
    input  cls_e    cls,
    input  ctx_e    ctx,
    input  logic    map_bit,
    input  logic    cnt4,
    output policy_t pol,
    output logic    ind_map
);

    logic seq_ctx;
    logic seq_fmt;

    always_comb begin
        seq_ctx = (ctx == CTX_TRAP) || (ctx == CTX_INTR);
        seq_fmt = seq_ctx && ((cls == CLS_PUSH) || (cls == CLS_MODT));

        pol.idx_ok  = 1'b1;
        pol.map     = map_bit;
        pol.real_a  = !map_bit;
        pol.clr_fld = 1'b0;
        pol.trunc   = 1'b0;
        pol.zero    = 1'b0;
        ind_map     = map_bit;

        if (cls == CLS_DIO) begin
            // device address: never mapped, not a memory address
            pol.map    = 1'b0;
            pol.real_a = 1'b0;
            pol.trunc  = 1'b1;
        end else if (cls == CLS_STK) begin
            pol.idx_ok = 1'b0;
            pol.map    = 1'b0;
            pol.real_a = 1'b1;
            pol.zero   = 1'b1;
            ind_map    = 1'b0;
        end else if (seq_fmt) begin
            pol.idx_ok = 1'b0;
            if (ctx == CTX_INTR) begin
                pol.map = (cls == CLS_MODT) && cnt4 && map_bit;
            end else begin
                pol.map     = map_bit;
                pol.clr_fld = (cls == CLS_MODT) && map_bit;
            end
            pol.real_a = !pol.map;
            ind_map    = pol.map;
        end
    end

endmodule

// File: rtl/eag_addr.sv
module eag_addr
    import eag_pkg::*;
#(
    parameter int AW     = 20,
    parameter int IOW    = 16,
    parameter int CLR_LO = 12,
    parameter int CLR_HI = 14
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] xval,
    input  logic          idx_en,
    input  policy_t       pol,
    output logic [AW-1:0] addr
);

    localparam int PADW = AW - IOW;

    logic [AW-1:0] keep_mask;
    logic [AW-1:0] sum;

    // Mask that clears the ignored field when mapping a trapped reference
    for (genvar g = 0; g < AW; g++) begin : g_mask
        assign keep_mask[g] = !((g >= CLR_LO) && (g <= CLR_HI));
    end

    always_comb begin
        sum = base + ((pol.idx_ok && idx_en) ? xval : '0);
        if (pol.zero) begin
            addr = '0;
        end else if (pol.trunc) begin
            addr = {{PADW{1'b0}}, sum[IOW-1:0]};
        end else if (pol.clr_fld) begin
            addr = sum & keep_mask;
        end else begin
            addr = sum;
        end
    end

endmodule

// File: rtl/eag_core.sv
module eag_core
    import eag_pkg::*;
#(
    parameter int AW     = 20,
    parameter int IOW    = 16,
    parameter int CLR_LO = 12,
    parameter int CLR_HI = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    cls_i,
    input  logic [1:0]    ctx_i,
    input  logic [AW-1:0] ref_i,
    input  logic          idx_en_i,
    input  logic          ind_en_i,
    input  logic [AW-1:0] xval_i,
    input  logic          map_bit_i,
    input  logic          cnt4_i,
    output logic          ind_req_o,
    output logic [AW-1:0] ind_addr_o,
    output logic          ind_map_o,
    input  logic          ind_valid_i,
    input  logic [AW-1:0] ind_word_i,
    output logic          done_o,
    output logic [AW-1:0] addr_o,
    output logic          use_map_o,
    output logic          real_o
);

    typedef struct packed {
        state_e        state;
        cls_e          cls;
        ctx_e          ctx;
        logic          idx_en;
        logic [AW-1:0] xval;
        logic          map_bit;
        logic          cnt4;
        logic          ind_req;
        logic [AW-1:0] ind_addr;
        logic          ind_map;
        logic          done;
        logic [AW-1:0] addr;
        logic          use_map;
        logic          real_a;
    } regs_t;

    regs_t r_d, r_q;

    // Selected request fields: live inputs while idle, latched while waiting
    cls_e          sel_cls;
    ctx_e          sel_ctx;
    logic          sel_map_bit;
    logic          sel_cnt4;
    logic          sel_idx_en;
    logic [AW-1:0] sel_xval;
    logic [AW-1:0] sel_base;
    policy_t       pol;
    logic          pol_ind_map;
    logic [AW-1:0] calc_addr;
    logic          want_ind;

    always_comb begin
        if (r_q.state == ST_WAIT) begin
            sel_cls     = r_q.cls;
            sel_ctx     = r_q.ctx;
            sel_map_bit = r_q.map_bit;
            sel_cnt4    = r_q.cnt4;
            sel_idx_en  = r_q.idx_en;
            sel_xval    = r_q.xval;
            sel_base    = ind_word_i;
        end else begin
            sel_cls     = cls_e'(cls_i);
            sel_ctx     = ctx_e'(ctx_i);
            sel_map_bit = map_bit_i;
            sel_cnt4    = cnt4_i;
            sel_idx_en  = idx_en_i;
            sel_xval    = xval_i;
            sel_base    = ref_i;
        end
    end

    eag_policy i_policy (
        .cls     (sel_cls),
        .ctx     (sel_ctx),
        .map_bit (sel_map_bit),
        .cnt4    (sel_cnt4),
        .pol     (pol),
        .ind_map (pol_ind_map)
    );

    eag_addr #(
        .AW     (AW),
        .IOW    (IOW),
        .CLR_LO (CLR_LO),
        .CLR_HI (CLR_HI)
    ) i_addr (
        .base   (sel_base),
        .xval   (sel_xval),
        .idx_en (sel_idx_en),
        .pol    (pol),
        .addr   (calc_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        want_ind = ind_en_i && (cls_e'(cls_i) != CLS_STK);

        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.cls     = sel_cls;
                    r_d.ctx     = sel_ctx;
                    r_d.idx_en  = idx_en_i;
                    r_d.xval    = xval_i;
                    r_d.map_bit = map_bit_i;
                    r_d.cnt4    = cnt4_i;
                    if (want_ind) begin
                        r_d.state    = ST_WAIT;
                        r_d.ind_req  = 1'b1;
                        r_d.ind_addr = ref_i;
                        r_d.ind_map  = pol_ind_map;
                    end else begin
                        r_d.done    = 1'b1;
                        r_d.addr    = calc_addr;
                        r_d.use_map = pol.map;
                        r_d.real_a  = pol.real_a;
                    end
                end
            end
            ST_WAIT: begin
                if (ind_valid_i) begin
                    r_d.state   = ST_IDLE;
                    r_d.ind_req = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.addr    = calc_addr;
                    r_d.use_map = pol.map;
                    r_d.real_a  = pol.real_a;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ind_req_o  = r_q.ind_req;
    assign ind_addr_o = r_q.ind_addr;
    assign ind_map_o  = r_q.ind_map;
    assign done_o     = r_q.done;
    assign addr_o     = r_q.addr;
    assign use_map_o  = r_q.use_map;
    assign real_o     = r_q.real_a;

endmodule

// File: rtl/eag_core_chk.sv
module eag_core_chk #(
    parameter int AW  = 20,
    parameter int IOW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [2:0]    cls_i,
    input logic          ind_en_i,
    input logic          ind_req_o,
    input logic [AW-1:0] ind_addr_o,
    input logic          ind_valid_i,
    input logic          done_o,
    input logic [AW-1:0] addr_o,
    input logic          use_map_o,
    input logic          real_o
);

    // R2: a start without indirection completes on the next edge
    a_r2_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ind_req_o && (!ind_en_i || cls_i == 3'd4)) |=> done_o);

    // R10: pending request holds its address until the word arrives
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req_o && !ind_valid_i) |=> (ind_req_o && $stable(ind_addr_o)));

    // R10: accepted indirect word ends the request and completes
    a_r10_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req_o && ind_valid_i) |=> (done_o && !ind_req_o));

    // R12: no completion while the fetch is still pending
    a_r12_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_req_o && !ind_valid_i) |=> !done_o);

    // R5: an address is never both mapped and real
    a_r5_map_real_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(use_map_o && real_o));

    // R8: a device address carries nothing above its width
    a_r8_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !use_map_o && !real_o) |-> (addr_o[AW-1:IOW] == '0));

endmodule

bind eag_core eag_core_chk #(.AW(AW), .IOW(IOW)) i_eag_core_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cls_i       (cls_i),
    .ind_en_i    (ind_en_i),
    .ind_req_o   (ind_req_o),
    .ind_addr_o  (ind_addr_o),
    .ind_valid_i (ind_valid_i),
    .done_o      (done_o),
    .addr_o      (addr_o),
    .use_map_o   (use_map_o),
    .real_o      (real_o)
);

// File: tb/test_eag_core.sv
module test_eag_core;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  cls_i = '0;
    logic [1:0]  ctx_i = '0;
    logic [19:0] ref_i = '0;
    logic        idx_en_i = 1'b0;
    logic        ind_en_i = 1'b0;
    logic [19:0] xval_i = '0;
    logic        map_bit_i = 1'b0;
    logic        cnt4_i = 1'b0;
    logic        ind_req_o;
    logic [19:0] ind_addr_o;
    logic        ind_map_o;
    logic        ind_valid_i = 1'b0;
    logic [19:0] ind_word_i = '0;
    logic        done_o;
    logic [19:0] addr_o;
    logic        use_map_o;
    logic        real_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    eag_core i_eag_core (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cls_i(cls_i), .ctx_i(ctx_i),
        .ref_i(ref_i), .idx_en_i(idx_en_i), .ind_en_i(ind_en_i), .xval_i(xval_i),
        .map_bit_i(map_bit_i), .cnt4_i(cnt4_i), .ind_req_o(ind_req_o),
        .ind_addr_o(ind_addr_o), .ind_map_o(ind_map_o), .ind_valid_i(ind_valid_i),
        .ind_word_i(ind_word_i), .done_o(done_o), .addr_o(addr_o),
        .use_map_o(use_map_o), .real_o(real_o)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] c, input logic [1:0] x, input logic [19:0] r,
                         input logic ie, input logic nd, input logic [19:0] xv,
                         input logic mb, input logic c4);
        cls_i = c; ctx_i = x; ref_i = r; idx_en_i = ie; ind_en_i = nd;
        xval_i = xv; map_bit_i = mb; cnt4_i = c4;
    endtask

    // Direct request: done is sampled one edge after start
    task automatic run_direct(input string tag, input logic [19:0] ea,
                              input logic em, input logic er);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " done"}, {19'd0, done_o}, 20'd1);
        chk({tag, " ind_req"}, {19'd0, ind_req_o}, 20'd0);
        chk({tag, " addr"}, addr_o, ea);
        chk({tag, " map"}, {19'd0, use_map_o}, {19'd0, em});
        chk({tag, " real"}, {19'd0, real_o}, {19'd0, er});
        @(negedge clk);
        chk({tag, " done pulse"}, {19'd0, done_o}, 20'd0);
    endtask

    task automatic run_indirect(input string tag, input logic [19:0] word, input int hold,
                                input logic eim, input logic [19:0] ea,
                                input logic em, input logic er, input bit stray);
        logic [19:0] ref_saved;
        ref_saved = ref_i;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R10 ind_req"}, {19'd0, ind_req_o}, 20'd1);
        chk({tag, " R10 ind_addr"}, ind_addr_o, ref_saved);
        chk({tag, " ind_map"}, {19'd0, ind_map_o}, {19'd0, eim});
        for (int i = 0; i < hold; i++) begin
            if (stray && i == 0) begin
                start_i = 1'b1; ref_i = 20'h0BEEF; ind_en_i = 1'b0;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk({tag, " R10 hold"}, {19'd0, ind_req_o}, 20'd1);
            chk({tag, " R12 no done"}, {19'd0, done_o}, 20'd0);
        end
        ind_valid_i = 1'b1;
        ind_word_i = word;
        @(negedge clk);
        ind_valid_i = 1'b0;
        chk({tag, " R10 done"}, {19'd0, done_o}, 20'd1);
        chk({tag, " R10 req drop"}, {19'd0, ind_req_o}, 20'd0);
        chk({tag, " addr"}, addr_o, ea);
        chk({tag, " map"}, {19'd0, use_map_o}, {19'd0, em});
        chk({tag, " real"}, {19'd0, real_o}, {19'd0, er});
        @(negedge clk);
        chk({tag, " idle after"}, {19'd0, ind_req_o | done_o}, 20'd0);
    endtask

    task automatic t_reset();
        chk("R1 done", {19'd0, done_o}, 20'd0);
        chk("R1 ind_req", {19'd0, ind_req_o}, 20'd0);
        chk("R1 addr", addr_o, 20'd0);
        chk("R1 flags", {18'd0, use_map_o, real_o}, 20'd0);
    endtask

    task automatic t_normal();
        setup(3'd0, 2'd0, 20'h12345, 1'b1, 1'b0, 20'h00100, 1'b1, 1'b0);
        run_direct("R2 R3 general mapped", 20'h12445, 1'b1, 1'b0);
        setup(3'd0, 2'd0, 20'hFFFF0, 1'b1, 1'b0, 20'h00020, 1'b0, 1'b0);
        run_direct("R3 wrap", 20'h00010, 1'b0, 1'b1);
        setup(3'd2, 2'd0, 20'h01000, 1'b1, 1'b0, 20'h00003, 1'b1, 1'b0);
        run_direct("R3 modtest normal indexed", 20'h01003, 1'b1, 1'b0);
        setup(3'd1, 2'd3, 20'h02000, 1'b1, 1'b0, 20'h00004, 1'b0, 1'b0);
        run_direct("R3 push ctx3 indexed", 20'h02004, 1'b0, 1'b1);
        setup(3'd0, 2'd1, 20'h03000, 1'b1, 1'b0, 20'h00005, 1'b1, 1'b0);
        run_direct("R3 general in trap indexed", 20'h03005, 1'b1, 1'b0);
    endtask

    task automatic t_seq_format();
        setup(3'd1, 2'd1, 20'h0A0B0, 1'b1, 1'b0, 20'h11111, 1'b1, 1'b0);
        run_direct("R4 trap push no index", 20'h0A0B0, 1'b1, 1'b0);
        setup(3'd1, 2'd2, 20'h0A0B0, 1'b1, 1'b0, 20'h11111, 1'b1, 1'b0);
        run_direct("R4 R5 intr push real", 20'h0A0B0, 1'b0, 1'b1);
        setup(3'd2, 2'd2, 20'h04444, 1'b0, 1'b0, 20'h0, 1'b1, 1'b0);
        run_direct("R5 intr modtest real", 20'h04444, 1'b0, 1'b1);
        setup(3'd2, 2'd2, 20'h04444, 1'b1, 1'b0, 20'h00010, 1'b1, 1'b1);
        run_direct("R6 cnt4 mapped", 20'h04444, 1'b1, 1'b0);
        setup(3'd2, 2'd2, 20'h04444, 1'b0, 1'b0, 20'h0, 1'b0, 1'b1);
        run_direct("R6 cnt4 unmapped", 20'h04444, 1'b0, 1'b1);
        setup(3'd2, 2'd1, 20'hFFFFF, 1'b1, 1'b0, 20'h00001, 1'b1, 1'b0);
        run_direct("R7 trap modtest mapped clear", 20'hF8FFF, 1'b1, 1'b0);
        setup(3'd2, 2'd1, 20'hFFFFF, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
        run_direct("R7 trap modtest unmapped", 20'hFFFFF, 1'b0, 1'b1);
    endtask

    task automatic t_direct_io();
        setup(3'd3, 2'd0, 20'h1FFF0, 1'b1, 1'b0, 20'h00020, 1'b1, 1'b0);
        run_direct("R8 dio truncate", 20'h00010, 1'b0, 1'b0);
        setup(3'd3, 2'd1, 20'h2ABCD, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
        run_direct("R8 dio trap ctx", 20'h0ABCD, 1'b0, 1'b0);
        setup(3'd3, 2'd0, 20'h00400, 1'b1, 1'b1, 20'h00005, 1'b1, 1'b0);
        run_indirect("R9 dio indirect", 20'h3ABCD, 1, 1'b1, 20'h0ABD2, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_indirect();
        setup(3'd2, 2'd2, 20'h00080, 1'b1, 1'b1, 20'h00005, 1'b1, 1'b0);
        run_indirect("R10 R12 intr indirect", 20'h54321, 3, 1'b0, 20'h54321, 1'b0, 1'b1, 1'b1);
        setup(3'd2, 2'd1, 20'h00090, 1'b1, 1'b1, 20'h00005, 1'b1, 1'b0);
        run_indirect("R10 trap indirect", 20'h07123, 0, 1'b1, 20'h00123, 1'b1, 1'b0, 1'b0);
        setup(3'd0, 2'd0, 20'h000A0, 1'b1, 1'b1, 20'h00010, 1'b0, 1'b0);
        run_indirect("R10 normal indirect", 20'h00F00, 2, 1'b0, 20'h00F10, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_stack();
        setup(3'd4, 2'd2, 20'h12345, 1'b1, 1'b1, 20'h00777, 1'b1, 1'b1);
        run_direct("R11 stack pointer", 20'h00000, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_seq_format();
        t_direct_io();
        t_indirect();
        t_stack();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule